// File: doc/BRIEF.md
# Half-Bridge Gate Drive Generator

This block turns a free-running oscillator signal into the two gate commands of a half-bridge: one for the high-side switch and one for the low-side switch. A phase flop inverts on every falling edge of the oscillator, so the bridge runs at half the oscillator rate. Each switch is therefore selected for exactly half of every bridge period. Whenever the phase changes, both commands go low for a fixed number of system clocks before the newly selected switch is turned on.

Two protections act on the commands. A bootstrap-undervoltage flag holds the high-side command off. A saturation-current flag ends the present conduction interval early and sends a one-cycle request to raise the switching frequency. A force-start-up input overrides all other logic and holds the low side on and the high side off. The oscillator input is asynchronous and is synchronised inside the block. The level shifters and the power stage are not part of this block.

Top module: `hbg_gate_drive`

## Requirements
- R1: While reset is active, and after reset until the first oscillator falling edge, the low-side command is 1, the high-side command is 0 and the frequency request is 0. The low side is the selected phase at this point.
- R2: Let a falling edge of `osc_i` be driven between clock edges. The phase changes at the third rising clock edge after that. Rising edges of `osc_i` do not change the phase.
- R3: The high-side and low-side commands are never both 1 in the same cycle.
- R4: At a phase change both commands go to 0 and stay at 0 for exactly `DEAD_CYC` cycles. The newly selected command becomes 1 at the `DEAD_CYC`-th clock edge after the phase change.
- R5: While `boot_low_i` is sampled high, the high-side command is 0 from the next edge on. It returns at the first edge after the flag is sampled low, if the high side is selected and the dead time is over. The low-side command does not depend on this flag.
- R6: If `sat_i` is sampled high while one gate command is 1, that command goes to 0 at that edge. It stays at 0 for the rest of the half period. The other command still waits for the next phase change plus the dead time.
- R7: `freq_up_o` is high for exactly one cycle per truncation, in the cycle where the gate goes off. The pulse is not repeated while `sat_i` stays high. When `sat_i` is high while both commands are 0, it has no effect.
- R8: While `force_start_i` is sampled high, the next edge gives low side 1 and high side 0. Oscillator falling edges seen during force do not change the phase. After release, the low side is the selected phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_i | input | 1 | Asynchronous oscillator level |
| boot_low_i | input | 1 | High-side floating supply below its lockout level |
| sat_i | input | 1 | Switch current above its saturation rating |
| force_start_i | input | 1 | Hold the bridge in the start-up state |
| hs_on_o | output | 1 | High-side gate command |
| ls_on_o | output | 1 | Low-side gate command |
| freq_up_o | output | 1 | One-cycle request to raise the frequency |

## Verification
The bench sweeps the length of the half period. It checks every cycle against an arithmetic schedule: the phase change lands three edges after the oscillator falls, followed by exactly `DEAD_CYC` off cycles. A design that is off by one in the synchroniser or in the dead-time counter fails in a cycle next to the boundary. A flag held high would show a repeated or missing frequency pulse. A saturation flag that arrives inside the dead time would show a spurious cut. Two more cases are covered. A falling edge consumed during force must not flip the phase. An undervoltage window must blank only the high side and must hand it back on the next edge.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    // Selected half of the bridge period: 0 = low side, 1 = high side.
    typedef enum logic {
        SIDE_LO = 1'b0,
        SIDE_HI = 1'b1
    } side_e;

    function automatic side_e other_side(side_e s);
        return (s == SIDE_HI) ? SIDE_LO : SIDE_HI;
    endfunction

endpackage

// File: rtl/hbg_osc_sync.sv
module hbg_osc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o
);
    // Synchroniser stages plus one history stage for edge detection.
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-1:0], async_i};
    end

    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/hbg_deadtime.sv
module hbg_deadtime #(
    parameter int DEAD_CYC = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic clr_i,
    output logic expired_d_o
);
    localparam int CW = $clog2(DEAD_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i)              cnt_d = '0;
        else if (load_i)        cnt_d = CW'(DEAD_CYC);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // Next-state view so that gates register in the edge the count ends.
    assign expired_d_o = (cnt_d == '0);

endmodule

// File: rtl/hbg_gate_drive.sv
module hbg_gate_drive
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC    = 60,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_i,
    input  logic boot_low_i,
    input  logic sat_i,
    input  logic force_start_i,
    output logic hs_on_o,
    output logic ls_on_o,
    output logic freq_up_o
);
    typedef struct packed {
        side_e side;
        logic  cut;
        logic  hs;
        logic  ls;
        logic  fup;
    } st_t;

    localparam st_t ST_RESET = '{side: SIDE_LO, cut: 1'b0, hs: 1'b0, ls: 1'b1, fup: 1'b0};

    st_t  st_d, st_q;
    logic osc_fall;
    logic swap;
    logic dead_over;
    logic gate_active;

    hbg_osc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (osc_i),
        .fall_o  (osc_fall)
    );

    assign swap = osc_fall & ~force_start_i;

    hbg_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (swap),
        .clr_i       (force_start_i),
        .expired_d_o (dead_over)
    );

    assign gate_active = st_q.hs | st_q.ls;

    always_comb begin
        st_d     = st_q;
        st_d.fup = 1'b0;
        if (force_start_i) begin
            st_d.side = SIDE_LO;
            st_d.cut  = 1'b0;
            st_d.hs   = 1'b0;
            st_d.ls   = 1'b1;
        end else begin
            if (swap) begin
                st_d.side = other_side(st_q.side);
                st_d.cut  = 1'b0;
            end else if (sat_i && gate_active && !st_q.cut) begin
                st_d.cut = 1'b1;
                st_d.fup = 1'b1;
            end
            st_d.hs = (st_d.side == SIDE_HI) & dead_over & ~st_d.cut & ~boot_low_i;
            st_d.ls = (st_d.side == SIDE_LO) & dead_over & ~st_d.cut;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign hs_on_o   = st_q.hs;
    assign ls_on_o   = st_q.ls;
    assign freq_up_o = st_q.fup;

endmodule

// File: rtl/hbg_gate_drive_chk.sv
module hbg_gate_drive_chk (
    input logic clk,
    input logic rst_n,
    input logic boot_low_i,
    input logic force_start_i,
    input logic hs_on_o,
    input logic ls_on_o,
    input logic freq_up_o
);
    p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_on_o && ls_on_o));

    // R4: a rising gate had its partner off for the two cycles before (DEAD_CYC >= 2)
    p_dead_hs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on_o) |-> ($past(!ls_on_o) && $past(!ls_on_o, 2)));

    p_dead_ls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ls_on_o) && !$past(force_start_i)) |-> ($past(!hs_on_o) && $past(!hs_on_o, 2)));

    p_uv_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        boot_low_i |=> !hs_on_o);

    p_cut_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        freq_up_o |-> (!hs_on_o && !ls_on_o));

    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        freq_up_o |=> !freq_up_o);

    p_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_start_i |=> (ls_on_o && !hs_on_o));

endmodule

bind hbg_gate_drive hbg_gate_drive_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .boot_low_i    (boot_low_i),
    .force_start_i (force_start_i),
    .hs_on_o       (hs_on_o),
    .ls_on_o       (ls_on_o),
    .freq_up_o     (freq_up_o)
);

// File: tb/hbg_gate_drive_bench.sv
module hbg_gate_drive_bench;
    localparam int D = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc = 1'b1;
    logic uv = 1'b0;
    logic sat = 1'b0;
    logic frc = 1'b0;
    logic hs, ls, fup;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;
    logic cur_ph = 1'b0;
    logic last_hs = 1'b0;
    logic last_ls = 1'b1;

    always #10 clk = ~clk;

    hbg_gate_drive #(.DEAD_CYC(D), .SYNC_STAGES(2)) u_hbg_gate_drive (
        .clk           (clk),
        .rst_n         (rst_n),
        .osc_i         (osc),
        .boot_low_i    (uv),
        .sat_i         (sat),
        .force_start_i (frc),
        .hs_on_o       (hs),
        .ls_on_o       (ls),
        .freq_up_o     (fup)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic e_hs, logic e_ls, logic e_f);
        checks++;
        if (hs !== e_hs || ls !== e_ls || fup !== e_f) begin
            errs++;
            $display("FAIL %s t=%0t: hs/ls/fup actual=%b%b%b expected=%b%b%b",
                     req, $time, hs, ls, fup, e_hs, e_ls, e_f);
        end
        checks++;
        if (hs === 1'b1 && ls === 1'b1) begin
            errs++;
            $display("FAIL R3 t=%0t: actual hs=1 ls=1 expected not both", $time);
        end
    endtask

    // One half period: the oscillator falls now, the run lasts len samples.
    task automatic half(int len, int sat_k, int sat_len, int uv_k0, int uv_k1);
        logic nph;
        logic cut;
        logic p_on;
        logic e_hs, e_ls, e_f;
        string tag;
        nph  = ~cur_ph;
        cut  = 1'b0;
        p_on = last_hs | last_ls;
        osc  = 1'b0;
        for (int k = 1; k <= len; k++) begin
            tick();
            e_f = 1'b0;
            tag = "R2";
            if (k < 3) begin
                e_hs = last_hs;
                e_ls = last_ls;
            end else if (k < 3 + D) begin
                e_hs = 1'b0;
                e_ls = 1'b0;
                tag  = "R4";
            end else begin
                if (sat_k >= 0 && k == sat_k + 1 && p_on) begin
                    cut = 1'b1;
                    e_f = 1'b1;
                end
                e_hs = nph & ~cut;
                e_ls = ~nph & ~cut;
                if (uv_k0 >= 0 && k > uv_k0 && k <= uv_k1) begin
                    e_hs = 1'b0;
                    tag  = "R5";
                end
                if (cut) tag = e_f ? "R7" : "R6";
                if (k == 3 + D) tag = "R4";
            end
            chk(tag, e_hs, e_ls, e_f);
            p_on = e_hs | e_ls;
            if (k == 1) osc = 1'b1;
            sat = (sat_k >= 0 && k >= sat_k && k < sat_k + sat_len);
            uv  = (uv_k0 >= 0 && k >= uv_k0 && k < uv_k1);
        end
        sat = 1'b0;
        uv  = 1'b0;
        last_hs = e_hs;
        last_ls = e_ls;
        cur_ph  = nph;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1", 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        repeat (4) begin
            tick();
            chk("R1", 1'b0, 1'b1, 1'b0);
        end
        // R2/R4: sweep of half-period lengths, phases alternate
        for (int len = 3 + D + 1; len <= 3 + D + 6; len++) half(len, -1, 1, -1, -1);
        // R5: undervoltage on the high side, then on the low side (no effect)
        half(16, -1, 1, 9, 12);
        half(14, -1, 1, 8, 11);
        // R6/R7: cut on high side with sat held 3 cycles
        half(16, 10, 3, -1, -1);
        // R7: sat inside dead time is ignored
        half(14, 4, 1, -1, -1);
        half(14, -1, 1, -1, -1);
        // R6: cut on low side
        half(16, 9, 1, -1, -1);
        // R8: force from high-side conduction
        half(12, -1, 1, -1, -1);
        frc = 1'b1;
        tick();
        chk("R8", 1'b0, 1'b1, 1'b0);
        osc = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R8", 1'b0, 1'b1, 1'b0);
        end
        frc = 1'b0;
        tick();
        chk("R8", 1'b0, 1'b1, 1'b0);
        osc = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R8", 1'b0, 1'b1, 1'b0);
        end
        cur_ph  = 1'b0;
        last_hs = 1'b0;
        last_ls = 1'b1;
        half(12, -1, 1, -1, -1);
        half(12, -1, 1, -1, -1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule